// File: doc/BRIEF.md
# Burst SPI Master with Manual Start

This block is an SPI master for a peripheral bus. Software queues frames in an 8-entry transmit FIFO through a small register interface. The engine then clocks every queued frame out on MOSI, most significant bit first, and captures MISO into an 8-entry receive FIFO. Chip select stays low for the whole burst.

A control register holds the configuration:
- clock polarity and phase, giving the four usual SPI modes;
- an 8- or 16-bit frame;
- a 3-bit code that picks one of eight power-of-two SCLK divisors;
- a manual-start option.

With manual start selected, queued frames wait until software sets a start bit, and that bit clears itself when the burst ends. Without it, shifting begins as soon as the block is enabled and a frame is queued.

A status register reports FIFO levels, a sticky transmit-overflow flag and a mode-fault flag. The mode fault is raised when an external fault input goes low during a transfer. That fault aborts the burst and clears the global enable. A write-one-to-set register and a write-one-to-clear register maintain the interrupt mask.

Top module: `spi_burst_master`

## Requirements
- R1: The SCLK period is 2^(code+1) clock cycles, where code is CTRL[7:5] (000 gives divide by 2, 111 gives divide by 256).
- R2: CTRL[1] sets the SCLK idle level. With CTRL[2]=0, MISO is sampled on the leading SCLK edge and MOSI changes on the trailing edge. With CTRL[2]=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R3: CTRL[4:3]=01 selects 16-bit frames and every other code selects 8-bit frames. Frames go out MSB first. An 8-bit frame sends write data bits [7:0], and the received 8-bit frame is zero-extended.
- R4: With CTRL[8]=1, no frame is shifted until start bit CTRL[9] is written as 1. The start bit returns to 0 once the TX FIFO is empty and the last frame has completed.
- R5: With CTRL[8]=0 and enable CTRL[0]=1, shifting begins as soon as the TX FIFO holds a frame.
- R6: cs_n stays low across all consecutive frames of a burst. It rises half an SCLK period after the final SCLK edge.
- R7: Every transmitted frame adds one RX FIFO entry. A read of address 2 returns the oldest entry and removes it, and a read of an empty RX FIFO returns 0.
- R8: The TX FIFO holds 8 frames (written at address 1). A write to a full TX FIFO is dropped and sets sticky STATUS[4], which a write of 1 to STATUS[4] clears.
- R9: STATUS (address 3) bit 0 is mode fault, bit 1 TX full, bit 2 TX not full, bit 3 RX not empty and bit 5 busy. irq is the OR of STATUS[3:0] ANDed with the mask. A write of ones to address 4 sets mask bits and a write of ones to address 5 clears them. Both addresses read the mask.
- R10: Writes to CTRL fields [8:1] take effect only while CTRL[0] is 0. Enable and start are always writable.
- R11: fault_n low while a transfer is active raises cs_n on the next cycle, sets STATUS[0] and clears CTRL[0]. A write of 1 to STATUS[0] clears the flag.
- R12: Address 6 reads the fixed identification value, 16'h5A31 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX at address 2) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| irq | output | 1 | Masked interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| fault_n | input | 1 | Active-low external fault |

## Verification
A wrong shift register or edge-select state shows up at the bench's SPI slave model within one frame. It appears as a captured word that differs from the queued word, or as loopback data that reads back wrong from the RX FIFO. A divisor or timer fault shows up as a wrong spacing between SCLK rising edges, or a wrong gap before cs_n rises, within the first SCLK period of a burst. FIFO pointer or count faults show up at the status bits and the RX read order within one bus access. A failure to abort shows up at cs_n one cycle after fault_n falls.

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master #(
  parameter int          DEPTH = 8,
  parameter logic [15:0] ID    = 16'h5A31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  input  logic        fault_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;

  logic        en, cpol, cpha, manual, start, mf, ovf;
  logic [1:0]  wsel;
  logic [2:0]  div;
  logic [3:0]  irqm;

  logic [15:0] txmem [DEPTH];
  logic [15:0] rxmem [DEPTH];
  logic [AW-1:0] txwp, txrp, rxwp, rxrp;
  logic [CW-1:0] txcnt, rxcnt;

  st_t         st;
  logic [7:0]  tmr;
  logic [4:0]  ecnt;
  logic [15:0] shreg, rxsh;
  logic        sclk_q, mosi_q, cs_q;

  logic wide, tx_full, tx_empty, rx_full, rx_empty;
  logic wr_ctrl, wr_tx, wr_stat, wr_mset, wr_mclr;
  logic tx_push, rx_pop, rx_push, go, load, gap_end, fault_hit;
  logic [7:0]  half;
  logic [4:0]  last_e;
  logic [15:0] tx_al, rx_word;
  logic [3:0]  stat_lo;

  assign wide     = (wsel == 2'b01);
  assign half     = 8'd1 << div;
  assign last_e   = wide ? 5'd31 : 5'd15;
  assign tx_full  = (txcnt == CW'(DEPTH));
  assign tx_empty = (txcnt == '0);
  assign rx_full  = (rxcnt == CW'(DEPTH));
  assign rx_empty = (rxcnt == '0);

  assign wr_ctrl = bus_wr && bus_addr == 3'd0;
  assign wr_tx   = bus_wr && bus_addr == 3'd1;
  assign wr_stat = bus_wr && bus_addr == 3'd3;
  assign wr_mset = bus_wr && bus_addr == 3'd4;
  assign wr_mclr = bus_wr && bus_addr == 3'd5;
  assign tx_push = wr_tx && !tx_full;
  assign rx_pop  = bus_rd && bus_addr == 3'd2 && !rx_empty;

  assign fault_hit = !fault_n && st != S_IDLE;
  assign go        = en && !tx_empty && (!manual || start);
  assign gap_end   = st == S_GAP && tmr == 8'd0;
  assign load      = !fault_hit && go && (st == S_IDLE || gap_end);
  assign rx_push   = !fault_hit && gap_end && !rx_full;

  assign tx_al   = wide ? txmem[txrp] : {txmem[txrp][7:0], 8'h00};
  assign rx_word = wide ? rxsh : {8'h00, rxsh[7:0]};

  assign stat_lo = {!rx_empty, !tx_full, tx_full, mf};
  assign irq     = |(stat_lo & irqm);
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign cs_n    = cs_q;

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {6'b0, start, manual, div, wsel, cpha, cpol, en};
      3'd2:    bus_rdata = rx_empty ? 16'h0000 : rxmem[rxrp];
      3'd3:    bus_rdata = {10'b0, st != S_IDLE, ovf, stat_lo};
      3'd4,
      3'd5:    bus_rdata = {12'b0, irqm};
      3'd6:    bus_rdata = ID;
      default: bus_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; cpol <= 1'b0; cpha <= 1'b0; wsel <= 2'b00; div <= 3'd0;
      manual <= 1'b0; start <= 1'b0; mf <= 1'b0; ovf <= 1'b0; irqm <= 4'h0;
    end else begin
      if (wr_ctrl) begin
        en    <= bus_wdata[0];
        start <= bus_wdata[9];
        if (!en) begin
          cpol   <= bus_wdata[1];
          cpha   <= bus_wdata[2];
          wsel   <= bus_wdata[4:3];
          div    <= bus_wdata[7:5];
          manual <= bus_wdata[8];
        end
      end else if (start && ((st == S_IDLE && tx_empty) || (gap_end && !go))) begin
        start <= 1'b0;
      end
      if (wr_stat && bus_wdata[0]) mf  <= 1'b0;
      if (wr_stat && bus_wdata[4]) ovf <= 1'b0;
      if (wr_tx && tx_full)        ovf <= 1'b1;
      if (wr_mset) irqm <= irqm | bus_wdata[3:0];
      if (wr_mclr) irqm <= irqm & ~bus_wdata[3:0];
      if (fault_hit) begin
        mf <= 1'b1; en <= 1'b0; start <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txmem[txwp] <= bus_wdata;
    if (rx_push) rxmem[rxwp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txwp <= '0; txrp <= '0; txcnt <= '0;
      rxwp <= '0; rxrp <= '0; rxcnt <= '0;
    end else begin
      if (tx_push) txwp <= txwp + 1'b1;
      if (load)    txrp <= txrp + 1'b1;
      txcnt <= txcnt + CW'(tx_push) - CW'(load);
      if (rx_push) rxwp <= rxwp + 1'b1;
      if (rx_pop)  rxrp <= rxrp + 1'b1;
      rxcnt <= rxcnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= 8'd0; ecnt <= 5'd0; shreg <= 16'h0; rxsh <= 16'h0;
      sclk_q <= 1'b0; mosi_q <= 1'b0; cs_q <= 1'b1;
    end else if (fault_hit) begin
      st <= S_IDLE; cs_q <= 1'b1; sclk_q <= cpol;
    end else if (load) begin
      if (!cpha) begin
        mosi_q <= tx_al[15];
        shreg  <= {tx_al[14:0], 1'b0};
      end else begin
        shreg  <= tx_al;
      end
      cs_q <= 1'b0; sclk_q <= cpol; tmr <= half - 8'd1; ecnt <= 5'd0; st <= S_RUN;
    end else begin
      case (st)
        S_IDLE: begin
          cs_q <= 1'b1; sclk_q <= cpol;
        end
        S_RUN: begin
          if (tmr != 8'd0) tmr <= tmr - 8'd1;
          else begin
            tmr    <= half - 8'd1;
            sclk_q <= ~sclk_q;
            ecnt   <= ecnt + 5'd1;
            if (ecnt[0] == cpha) rxsh <= {rxsh[14:0], miso};
            else begin
              mosi_q <= shreg[15];
              shreg  <= {shreg[14:0], 1'b0};
            end
            if (ecnt == last_e) st <= S_GAP;
          end
        end
        S_GAP: begin
          if (tmr != 8'd0) tmr <= tmr - 8'd1;
          else begin
            cs_q <= 1'b1; st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_master_chk.sv
`timescale 1ns/1ps
module spi_burst_master_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sclk,
  input logic          cpol,
  input logic          cpha,
  input logic [1:0]    wsel,
  input logic [2:0]    div,
  input logic          en,
  input logic          manual,
  input logic          start,
  input logic          fault_n,
  input logic          mf,
  input logic          ovf,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [CW-1:0] txcnt
);
  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cpol) == cpol |-> sclk == cpol);

  // R11
  fault_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n && !cs_n |=> cs_n && mf && !en);

  // R8
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 3'd1 && txcnt == CW'(DEPTH) |=> ovf);

  // R10
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && bus_wr && bus_addr == 3'd0 |=>
      $stable(cpol) && $stable(cpha) && $stable(wsel) && $stable(div) && $stable(manual));

  // R4
  manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) && manual |-> start);
endmodule

bind spi_burst_master spi_burst_master_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .cpol(cpol), .cpha(cpha),
  .wsel(wsel), .div(div), .en(en), .manual(manual), .start(start),
  .fault_n(fault_n), .mf(mf), .ovf(ovf), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .txcnt(txcnt)
);

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0, bus_rdata;
  logic irq, sclk, mosi, miso, cs_n;
  logic fault_n = 1'b1;
  logic loop = 1'b1, miso_fix = 1'b0;

  assign miso = loop ? mosi : miso_fix;
  always #(CLK_NS/2) clk = ~clk;

  spi_burst_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .fault_n(fault_n)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // slave model
  logic t_cpol = 1'b0, t_cpha = 1'b0;
  logic [15:0] cap;
  int pcnt, rises;
  time t1, t2, t_edge, gap;

  always @(sclk) begin
    if (cs_n === 1'b0) begin
      if ((sclk != t_cpol) ^ t_cpha) cap = {cap[14:0], mosi};
      t_edge = $time;
      if (sclk === 1'b1) begin
        pcnt++;
        if (pcnt == 1) t1 = $time;
        if (pcnt == 2) t2 = $time;
      end
    end
  end
  always @(negedge cs_n) begin cap = 16'h0; pcnt = 0; end
  always @(posedge cs_n) begin rises++; gap = $time - t_edge; end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_burst();
    wait (cs_n === 1'b0);
    wait (cs_n === 1'b1);
    repeat (3) @(negedge clk);
  endtask

  // {cpol, cpha, wsel[1:0], div[2:0], data[15:0]}
  localparam logic [22:0] VEC [6] = '{
    {1'b0, 1'b0, 2'b00, 3'd0, 16'h00A5},
    {1'b0, 1'b1, 2'b00, 3'd1, 16'h003C},
    {1'b1, 1'b0, 2'b01, 3'd2, 16'hBEEF},
    {1'b1, 1'b1, 2'b01, 3'd3, 16'h1234},
    {1'b0, 1'b0, 2'b01, 3'd7, 16'h8001},
    {1'b1, 1'b1, 2'b10, 3'd5, 16'hFF81}
  };

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R6 reset cs_n", cs_n, 1);
    check("R2 reset sclk", sclk, 0);
    check("R9 reset irq", irq, 0);
    rd(3'd3, r); check("R9 reset status", r, 16'h0004);
    rd(3'd0, r); check("R10 reset ctrl", r, 16'h0000);
    rd(3'd6, r); check("R12 id", r, 16'h5A31);

    // overflow with engine disabled
    for (int i = 0; i < 9; i++) wr(3'd1, 16'(i + 1));
    rd(3'd3, r); check("R8 full+overflow", r, 16'h0012);
    wr(3'd3, 16'h0010);
    rd(3'd3, r); check("R8 overflow clear", r, 16'h0002);

    // auto mode drains all 8 in one burst
    rises = 0;
    wr(3'd0, 16'h0001);
    wait_burst();
    check("R6 one cs rise for burst", rises, 1);
    check("R5 auto drained", cap[7:0], 8'h08);
    for (int i = 0; i < 8; i++) begin
      rd(3'd2, r); check("R7 rx order", r, 16'(i + 1));
    end
    rd(3'd2, r); check("R7 empty read zero", r, 16'h0000);
    rd(3'd3, r); check("R9 status idle", r, 16'h0004);

    // interrupt mask
    wr(3'd4, 16'h0008);
    rd(3'd4, r); check("R9 mask set", r, 16'h0008);
    check("R9 irq masked empty", irq, 0);
    wr(3'd1, 16'h005A);
    wait_burst();
    check("R9 irq rx not empty", irq, 1);
    wr(3'd5, 16'h0008);
    check("R9 irq cleared", irq, 0);
    rd(3'd5, r); check("R9 mask read", r, 16'h0000);
    rd(3'd2, r); check("R7 loopback", r, 16'h005A);
    wr(3'd4, 16'h0004);
    check("R9 irq tx not full", irq, 1);
    wr(3'd5, 16'h0004);

    // config lock while enabled
    wr(3'd0, 16'h0003);
    rd(3'd0, r); check("R10 cpol locked", r[1:0], 2'b01);

    // constant MISO, 8-bit zero extend
    loop = 1'b0; miso_fix = 1'b1;
    wr(3'd1, 16'h0000);
    wait_burst();
    rd(3'd2, r); check("R3 8-bit zero extend", r, 16'h00FF);
    loop = 1'b1;
    wr(3'd0, 16'h0000);

    // vector table, manual start
    for (int i = 0; i < 6; i++) begin
      logic [15:0] cfg, exp;
      logic [2:0] dv;
      cfg = {7'b0, 1'b1, VEC[i][18:16], VEC[i][20:19], VEC[i][21], VEC[i][22], 1'b1};
      dv  = VEC[i][18:16];
      exp = (VEC[i][20:19] == 2'b01) ? VEC[i][15:0] : {8'h00, VEC[i][7:0]};
      t_cpol = VEC[i][22]; t_cpha = VEC[i][21];
      wr(3'd0, cfg);
      wr(3'd1, VEC[i][15:0]);
      repeat (20) @(negedge clk);
      check("R4 held before start", cs_n, 1);
      check("R2 idle level", sclk, t_cpol);
      wr(3'd0, cfg | 16'h0200);
      wait_burst();
      check("R3 slave capture", (VEC[i][20:19] == 2'b01) ? cap : {8'h00, cap[7:0]}, exp);
      check("R1 sclk period", 32'(t2 - t1), 32'(CLK_NS * (2 << dv)));
      check("R6 cs gap", 32'(gap), 32'(CLK_NS * (1 << dv)));
      rd(3'd0, r); check("R4 start self-clear", r[9], 0);
      rd(3'd2, r); check("R2 loopback rx", r, exp);
      check("R2 idle after", sclk, t_cpol);
      wr(3'd0, 16'h0000);
    end

    // mode fault
    t_cpol = 1'b0; t_cpha = 1'b0;
    wr(3'd0, 16'h01E9);
    wr(3'd1, 16'hAAAA);
    wr(3'd0, 16'h03E9);
    repeat (300) @(negedge clk);
    check("R11 active before fault", cs_n, 0);
    fault_n = 1'b0;
    @(negedge clk);
    check("R11 cs released", cs_n, 1);
    fault_n = 1'b1;
    rd(3'd3, r); check("R11 fault status", r, 16'h0005);
    rd(3'd0, r); check("R11 enable cleared", r[0], 0);
    wr(3'd3, 16'h0001);
    rd(3'd3, r); check("R11 fault clear", r, 16'h0004);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule